// File: doc/BRIEF.md
# Mailbox request dispatcher

This block sits between a host register port and a set of downstream channel agents. A host write to the request window carries a channel number in its four low bits. The dispatcher hands the word straight to that channel when the channel is idle and nothing older for it is waiting. A word for a busy channel is parked in a small deferred queue. The queue drains on its own: whenever a channel is idle, its oldest parked word goes out. At most one word goes to the channels in any cycle.

In the other direction, each channel raises an available flag when it holds a response. The dispatcher scans the flags from channel 0 upward and moves one response word per cycle into the host-bound inbound queue, which belongs to a neighbouring block. A full indication from that queue holds the scan back. Requests that cannot be taken are reported on a one-cycle drop pulse. The deferred queue's occupancy can be read back as a status word.

Top module: `mbx_dispatch`

## Requirements
- R1: A write is a request only when `wr_en` is high and `wr_addr` is one of 0xA0, 0xA4, 0xA8 or 0xAC. Bits [3:0] of `wr_data` name the target channel. A write to any other address produces no channel write and no drop pulse.
- R2: A request for a channel below `NUM_CH` is forwarded in the same cycle under three conditions: the deferred queue is not full, the channel's busy input is low, and no entry for that channel is parked. Forwarding raises `chan_wr_valid` for that channel alone and carries the whole 32-bit word on `chan_wr_data`. No channel is ever written while its busy input is high.
- R3: A valid request that cannot be forwarded because its channel is busy, or because it already has parked entries, is appended to the deferred queue. It produces neither a channel write nor a drop pulse in that cycle.
- R4: A request arriving while the deferred queue holds `QDEPTH` entries is dropped. `req_drop` pulses for that cycle and the queue contents are unchanged.
- R5: A request whose channel number is `NUM_CH` or more is dropped with a `req_drop` pulse and no channel write.
- R6: With `rd_addr` = 0xB8, `rd_data` returns the queue status: bit 31 set when full, bit 30 set when empty, bits [7:0] the entry count, and all other bits 0. Any other read address returns 0.
- R7: In a cycle with no direct forward, the oldest parked entry whose channel is idle is sent to its channel and removed. Entries for busy channels are skipped and keep their order.
- R8: At most one bit of `chan_wr_valid` is high in any cycle.
- R9: When `inq_full` is low and at least one `chan_avail` bit is set, the lowest-numbered such channel gets a `chan_rd_pop` pulse. In the same cycle `inq_push` rises with that channel's word from `chan_rd_data` on `inq_data`. At most one channel is popped per cycle.
- R10: While `inq_full` is high, no `chan_rd_pop` and no `inq_push` occur.
- R11: After reset the deferred queue is empty, so the status word reads 0x4000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte offset |
| wr_data | input | 32 | Host write word; bits [3:0] are the channel |
| rd_addr | input | 8 | Host read byte offset |
| rd_data | output | 32 | Host read word (queue status at 0xB8) |
| chan_busy | input | NUM_CH | Per-channel busy indication |
| chan_wr_valid | output | NUM_CH | One-cycle write strobe to a channel |
| chan_wr_data | output | 32 | Word delivered to the strobed channel |
| chan_avail | input | NUM_CH | Per-channel response-available flag |
| chan_rd_data | input | NUM_CH*32 | Response word of each channel, channel 0 in the low bits |
| chan_rd_pop | output | NUM_CH | One-cycle read strobe taking a channel's response |
| inq_full | input | 1 | Inbound queue cannot accept a word |
| inq_push | output | 1 | Push strobe to the inbound queue |
| inq_data | output | 32 | Word pushed to the inbound queue |
| req_drop | output | 1 | One-cycle pulse for each dropped request |

## Verification
Every output is combinational in the cycle its inputs are presented: channel writes, drop pulses, pops and the inbound push all answer in that cycle. The deferred queue changes only at the next rising edge. A parked word, or a removal, therefore shows up in the status word and in the drain choice one cycle after the request that caused it. The bench drives each cycle's inputs at the falling edge and compares all outputs 2 ns later against a reference queue it keeps itself. It advances that reference only after the rising edge, which reproduces the one-cycle lag of the queue state.

// File: rtl/mbx_disp_pkg.sv
// Shared constants, types and helpers of the mailbox request dispatcher.
// Assumes a byte-addressed register window with 32-bit words.
package mbx_disp_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int CHID_W    = 4;
    localparam int CHID_SPAN = 1 << CHID_W;

    localparam logic [ADDR_W-1:0] REQ_LO  = 8'hA0;
    localparam logic [ADDR_W-1:0] REQ_HI  = 8'hAC;
    localparam logic [ADDR_W-1:0] OQ_STAT = 8'hB8;
    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CHID_W-1:0] chid_t;

    // Channel field of a request word
    function automatic chid_t word_chan(input word_t w);
        return w[CHID_W-1:0];
    endfunction

    // True for a word-aligned offset inside the request window
    function automatic logic is_req_addr(input logic [ADDR_W-1:0] a);
        return (a >= REQ_LO) && (a <= REQ_HI) && (a[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/mbx_defer_queue.sv
// Deferred request queue. Holds words whose channel was busy, in arrival order.
// Each cycle it offers the oldest entry whose channel is idle; removing an
// entry closes the gap by shifting younger entries down one slot.
// Assumes: push is never raised while full without a same-cycle drain, and
// every stored word carries a channel number below NUM_CH.
module mbx_defer_queue
    import mbx_disp_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int NUM_CH = 9,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  word_t             push_word,
    input  logic [NUM_CH-1:0] ch_busy,
    input  logic              drain_en,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic [NUM_CH-1:0] ch_pending,
    output logic              drain_valid,
    output word_t             drain_word
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t              mem_q [DEPTH];
    word_t              mem_n [DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_after;
    logic [CHID_SPAN-1:0] busy_ext;
    logic [CHID_SPAN-1:0] pend_ext;
    logic [IDX_W-1:0]   pick;
    logic               found;

    // Widen the busy vector to the full channel-number space
    always_comb begin
        busy_ext = '0;
        busy_ext[NUM_CH-1:0] = ch_busy;
    end

    // Mark every channel that owns at least one live entry
    always_comb begin
        pend_ext = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt_q) pend_ext[word_chan(mem_q[i])] = 1'b1;
        end
    end

    // Find the oldest live entry whose channel is idle
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CNT_W'(i) < cnt_q && !busy_ext[word_chan(mem_q[i])]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    assign drain_valid = drain_en && found;
    assign drain_word  = mem_q[pick];
    assign cnt_after   = cnt_q - CNT_W'(drain_valid);

    // Close the gap left by a drained entry, then append any new word
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_n[i] = (drain_valid && IDX_W'(i) >= pick) ? mem_q[(i + 1) % DEPTH] : mem_q[i];
            if (push && CNT_W'(i) == cnt_after) mem_n[i] = push_word;
        end
    end

    // State update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_after + CNT_W'(push);
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
        end
    end

    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign count      = cnt_q;
    assign ch_pending = pend_ext[NUM_CH-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && push && !drain_valid)); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R4
    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> !busy_ext[word_chan(drain_word)]); // R7
endmodule

// File: rtl/mbx_req_route.sv
// Request decoder and router. Decides, for a host write in the current
// cycle, whether the word goes straight to its channel, into the deferred
// queue, or is dropped. Assumes NUM_CH is at most 16.
module mbx_req_route
    import mbx_disp_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [NUM_CH-1:0] chan_busy,
    input  logic              q_full,
    input  logic [NUM_CH-1:0] q_pending,
    output logic              fwd_direct,
    output logic              q_push,
    output logic              req_drop,
    output chid_t             req_chan
);
    logic                 req;
    logic                 ch_ok;
    logic [CHID_SPAN-1:0] busy_ext;
    logic [CHID_SPAN-1:0] pend_ext;

    // Widen per-channel vectors so any 4-bit channel number can index them
    always_comb begin
        busy_ext = '0;
        pend_ext = '0;
        busy_ext[NUM_CH-1:0] = chan_busy;
        pend_ext[NUM_CH-1:0] = q_pending;
    end

    // Classify the current write
    always_comb begin
        req_chan   = word_chan(wr_data);
        req        = wr_en && is_req_addr(wr_addr);
        ch_ok      = int'(req_chan) < NUM_CH;
        req_drop   = req && (!ch_ok || q_full);
        fwd_direct = req && !req_drop && !busy_ext[req_chan] && !pend_ext[req_chan];
        q_push     = req && !req_drop && !fwd_direct;
    end

    AST_BAD_CHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_req_addr(wr_addr) && int'(word_chan(wr_data)) >= NUM_CH)
        |-> (req_drop && !q_push && !fwd_direct)); // R5
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_direct, q_push, req_drop})); // R3
    AST_NON_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_req_addr(wr_addr) |-> !(fwd_direct || q_push || req_drop)); // R1
endmodule

// File: rtl/mbx_resp_collect.sv
// Response collector. Picks the lowest-numbered channel that has a response
// and, when the inbound queue has room, pops that channel and pushes its
// word in the same cycle. Assumes a channel presents a valid word whenever
// its available flag is set.
module mbx_resp_collect
    import mbx_disp_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        chan_avail,
    input  logic [NUM_CH*WORD_W-1:0] chan_rd_data,
    input  logic                     inq_full,
    output logic [NUM_CH-1:0]        chan_rd_pop,
    output logic                     inq_push,
    output word_t                    inq_data
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SEL_W-1:0] sel;
    logic             hit;

    // Ascending-priority scan of the available flags
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (chan_avail[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end

    // Move one word when the inbound queue has room
    assign inq_push    = hit && !inq_full;
    assign chan_rd_pop = inq_push ? (NUM_CH'(1) << sel) : '0;
    assign inq_data    = chan_rd_data[sel*WORD_W +: WORD_W];

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        inq_full |-> (!inq_push && chan_rd_pop == '0)); // R10
    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_rd_pop)); // R9
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rd_pop & ~chan_avail) == '0); // R9
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rd_pop != '0) |-> ((chan_avail & (chan_rd_pop - NUM_CH'(1))) == '0)); // R9
endmodule

// File: rtl/mbx_dispatch.sv
// Mailbox request dispatcher, top level. Routes host request words to
// channel agents (directly or through the deferred queue), gathers channel
// responses into the inbound queue, and exposes the deferred queue status.
// Assumes 2 <= NUM_CH <= 16 and QDEPTH <= 255.
module mbx_dispatch
    import mbx_disp_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int QDEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [7:0]               rd_addr,
    output logic [31:0]              rd_data,
    input  logic [NUM_CH-1:0]        chan_busy,
    output logic [NUM_CH-1:0]        chan_wr_valid,
    output logic [31:0]              chan_wr_data,
    input  logic [NUM_CH-1:0]        chan_avail,
    input  logic [NUM_CH*32-1:0]     chan_rd_data,
    output logic [NUM_CH-1:0]        chan_rd_pop,
    input  logic                     inq_full,
    output logic                     inq_push,
    output logic [31:0]              inq_data,
    output logic                     req_drop
);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic              fwd_direct;
    logic              q_push;
    chid_t             req_chan;
    logic              q_full;
    logic              q_empty;
    logic [CNT_W-1:0]  q_count;
    logic [NUM_CH-1:0] q_pending;
    logic              drain_valid;
    word_t             drain_word;
    chid_t             out_chan;
    logic [CHID_SPAN-1:0] out_sel;

    mbx_req_route #(.NUM_CH(NUM_CH)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .chan_busy  (chan_busy),
        .q_full     (q_full),
        .q_pending  (q_pending),
        .fwd_direct (fwd_direct),
        .q_push     (q_push),
        .req_drop   (req_drop),
        .req_chan   (req_chan)
    );

    mbx_defer_queue #(.DEPTH(QDEPTH), .NUM_CH(NUM_CH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (q_push),
        .push_word   (wr_data),
        .ch_busy     (chan_busy),
        .drain_en    (!fwd_direct),
        .full        (q_full),
        .empty       (q_empty),
        .count       (q_count),
        .ch_pending  (q_pending),
        .drain_valid (drain_valid),
        .drain_word  (drain_word)
    );

    mbx_resp_collect #(.NUM_CH(NUM_CH)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_avail   (chan_avail),
        .chan_rd_data (chan_rd_data),
        .inq_full     (inq_full),
        .chan_rd_pop  (chan_rd_pop),
        .inq_push     (inq_push),
        .inq_data     (inq_data)
    );

    // Single channel write port: a direct forward wins over a queue drain
    always_comb begin
        out_chan     = fwd_direct ? req_chan : word_chan(drain_word);
        chan_wr_data = fwd_direct ? wr_data : drain_word;
        out_sel      = (fwd_direct || drain_valid) ? (CHID_SPAN'(1) << out_chan) : '0;
        chan_wr_valid = out_sel[NUM_CH-1:0];
    end

    // Status read-back of the deferred queue
    always_comb begin
        rd_data = '0;
        if (rd_addr == OQ_STAT) begin
            rd_data[STAT_FULL_BIT]  = q_full;
            rd_data[STAT_EMPTY_BIT] = q_empty;
            rd_data[7:0]            = 8'(q_count);
        end
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_wr_valid)); // R8
    AST_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_wr_valid & chan_busy) == '0); // R2
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OQ_STAT) |-> !(rd_data[STAT_FULL_BIT] && rd_data[STAT_EMPTY_BIT])); // R6
endmodule

// File: tb/test_mbx_dispatch.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared each cycle against a reference queue kept in the bench.
module test_mbx_dispatch;
    localparam int NCH = 9;
    localparam int QD  = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               wr_en;
    logic [7:0]         wr_addr;
    logic [31:0]        wr_data;
    logic [7:0]         rd_addr;
    logic [31:0]        rd_data;
    logic [NCH-1:0]     chan_busy;
    logic [NCH-1:0]     chan_wr_valid;
    logic [31:0]        chan_wr_data;
    logic [NCH-1:0]     chan_avail;
    logic [NCH*32-1:0]  chan_rd_data;
    logic [NCH-1:0]     chan_rd_pop;
    logic               inq_full;
    logic               inq_push;
    logic [31:0]        inq_data;
    logic               req_drop;

    mbx_dispatch #(.NUM_CH(NCH), .QDEPTH(QD)) i_mbx_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_busy(chan_busy),
        .chan_wr_valid(chan_wr_valid), .chan_wr_data(chan_wr_data),
        .chan_avail(chan_avail), .chan_rd_data(chan_rd_data), .chan_rd_pop(chan_rd_pop),
        .inq_full(inq_full), .inq_push(inq_push), .inq_data(inq_data), .req_drop(req_drop)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [31:0] mq [QD];
    int mcount = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit is_req(input logic en, input logic [7:0] a);
        return en && (a == 8'hA0 || a == 8'hA4 || a == 8'hA8 || a == 8'hAC);
    endfunction

    function automatic logic [31:0] exp_status(input logic [7:0] a);
        if (a != 8'hB8) return 32'h0;
        return {mcount == QD, mcount == 0, 22'h0, 8'(mcount)};
    endfunction

    // Present each channel's response word for this cycle
    task automatic fill_resp();
        for (int c = 0; c < NCH; c++) chan_rd_data[c*32 +: 32] = {8'hD0, 4'(c), 20'(cyc)};
    endtask

    // One cycle: inputs already driven at the falling edge
    task automatic step();
        logic [3:0] ch;
        bit req, drop, direct, push, pend, busy_ch;
        int didx, sel;
        logic [15:0] ev;
        logic [31:0] ew, ep;
        string tag;
        fill_resp();
        #2;
        req  = is_req(wr_en, wr_addr);
        ch   = wr_data[3:0];
        pend = 0;
        for (int i = 0; i < mcount; i++) if (mq[i][3:0] == ch) pend = 1;
        busy_ch = (int'(ch) < NCH) ? chan_busy[ch] : 1'b1;
        drop   = req && (int'(ch) >= NCH || mcount == QD);
        direct = req && !drop && !busy_ch && !pend;
        push   = req && !drop && !direct;
        didx = -1;
        if (!direct)
            for (int i = 0; i < mcount; i++)
                if (didx < 0 && !chan_busy[mq[i][3:0]]) didx = i;
        ev = '0; ew = '0;
        if (direct) begin ev[ch] = 1'b1; ew = wr_data; tag = "R2 direct"; end
        else if (didx >= 0) begin ev[mq[didx][3:0]] = 1'b1; ew = mq[didx]; tag = "R7 drain"; end
        else if (push) tag = "R3 deferred";
        else if (wr_en && !req) tag = "R1 non-request";
        else tag = "R8 idle";
        chk(tag, 32'(chan_wr_valid), 32'(ev[NCH-1:0]));
        if (ev != '0) chk({tag, " data"}, chan_wr_data, ew);
        if (drop) chk((int'(ch) >= NCH) ? "R5 bad channel drop" : "R4 full drop", 32'(req_drop), 32'd1);
        else chk("R1 no drop", 32'(req_drop), 32'd0);
        chk("R6 status", rd_data, exp_status(rd_addr));
        sel = -1;
        for (int c = 0; c < NCH; c++) if (sel < 0 && chan_avail[c]) sel = c;
        ep = (sel >= 0 && !inq_full) ? (32'd1 << sel) : 32'd0;
        chk(inq_full ? "R10 pop" : "R9 pop", 32'(chan_rd_pop), ep);
        chk(inq_full ? "R10 push" : "R9 push", 32'(inq_push), 32'(ep != 0));
        if (ep != 0) chk("R9 data", inq_data, chan_rd_data[sel*32 +: 32]);
        @(posedge clk);
        if (didx >= 0) begin
            for (int i = didx; i < mcount - 1; i++) mq[i] = mq[i + 1];
            mcount--;
        end
        if (push) begin mq[mcount] = wr_data; mcount++; end
        cyc++;
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; wr_addr = 8'h00; wr_data = '0; rd_addr = 8'hB8;
        chan_avail = '0; inq_full = 0;
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        mcount = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        chan_busy = '0;
        chan_rd_data = '0;
        do_reset();
        // R11: status right after reset
        #2 chk("R11 reset status", rd_data, 32'h4000_0000);
        chk("R11 reset no write", 32'(chan_wr_valid), 32'd0);
        @(negedge clk);

        // Direct path to an idle channel
        put(8'hA4, 32'h1234_5673);
        // Non-request offsets are ignored
        put(8'hA2, 32'h0000_0001);
        put(8'hB0, 32'h0000_0002);
        // Park words while every channel is busy
        chan_busy = '1;
        put(8'hA0, 32'hAAAA_0011);
        put(8'hA8, 32'hBBBB_0022);
        put(8'hA0, 32'hCCCC_0031);
        put(8'hAC, 32'h0000_000C); // R5: channel 12
        put(8'hA0, 32'hDDDD_0043);
        put(8'hA0, 32'hEEEE_0045); // R4: queue full
        step();
        // R7: only channel 2 idles, its entry overtakes older ones
        chan_busy[2] = 1'b0;
        step();
        step();
        // R3: new word for a channel with parked entries stays in order
        chan_busy = '0;
        chan_busy[1] = 1'b1;
        put(8'hA0, 32'hFFFF_0003);
        chan_busy = '0;
        repeat (6) step();
        // R9/R10: collection with backpressure
        chan_avail = 9'b1_0010_1000;
        inq_full = 1; step();
        inq_full = 0; step();
        chan_avail = 9'b1_0000_0000; step();
        quiet();

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 8;
            wr_en   = ($urandom % 3) == 0;
            wr_addr = (r < 5) ? (8'hA0 + 8'(4 * (r % 4))) :
                      (r == 5) ? 8'hA2 : (r == 6) ? 8'hB8 : 8'h9C;
            wr_data = {$urandom % 32'h1000_0000, 4'(($urandom % 5 == 0) ? ($urandom % 16) : ($urandom % NCH))};
            for (int c = 0; c < NCH; c++) if ($urandom % 6 == 0) chan_busy[c] = ~chan_busy[c];
            for (int c = 0; c < NCH; c++) chan_avail[c] = ($urandom % 4) == 0;
            inq_full = ($urandom % 4) == 0;
            rd_addr  = ($urandom % 2) ? 8'hB8 : 8'hBC;
            step();
            if (n == 2000) begin
                quiet();
                do_reset();
                #2 chk("R11 mid-run reset status", rd_data, 32'h4000_0000);
                @(negedge clk);
            end
        end
        summary();
        $finish;
    end
endmodule